// File: doc/BRIEF.md
# Scalar Bit-Count and Min/Max Execution Unit

This unit is a single-stage integer execution slice for a small family of general-register operations: absolute value, population count, trailing-zero count, and the four maximum/minimum selections (signed and unsigned). Each min/max operation can take its second operand either from a register input or from an 8-bit immediate. The immediate is sign-extended for the signed variants and zero-extended for the unsigned variants.

A size select chooses 64-bit or 32-bit operation. In 32-bit mode only the low halves of the operands take part, and the upper half of the result is cleared. The arithmetic is combinational. The result is captured in a register on the clock edge where the input strobe is high, and a one-cycle output strobe comes with it. The unit has no condition-flag output and changes no state besides its own result register.

Top module: `bitcnt_minmax_alu`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. That result appears on the edge after the strobe. After a cycle with `in_valid` low, `out_valid` is 0 and `result` holds its previous value.
- R3: With opcode 0 (absolute value), the operand is negated when its sign bit (bit 63, or bit 31 in 32-bit mode) is set, and passed through unchanged otherwise. The most negative value wraps to itself.
- R4: With opcode 1 (population count), the result is the number of set bits in the operand at the active width. The count is formed per byte and then summed.
- R5: With opcode 2 (trailing-zero count), the result is the index of the lowest set bit. An all-zero operand gives the active width (64 or 32).
- R6: Opcode 3 (signed maximum) returns the first operand when it is signed-greater than the second, and the second otherwise. Opcode 4 (signed minimum) returns the first operand when it is signed-less than the second, and the second otherwise.
- R7: Opcode 5 (unsigned maximum) and opcode 6 (unsigned minimum) follow the same selection rule as R6, using unsigned-higher and unsigned-lower comparisons.
- R8: When `use_imm` is 1, min/max operations compare against `imm8` instead of `src_b`. `imm8` is sign-extended for opcodes 3 and 4 and zero-extended for opcodes 5 and 6. `use_imm` has no effect on opcodes 0, 1 and 2.
- R9: When `wide` is 0 (32-bit mode), bits 63:32 of both operands have no effect, and bits 63:32 of the result are zero.
- R10: Opcode 7 is unassigned and produces an all-zero result, with `out_valid` still following R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Opcode (0 abs, 1 popcount, 2 trailing zeros, 3 smax, 4 smin, 5 umax, 6 umin) |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| use_imm | input | 1 | Min/max second operand from `imm8` |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm8 | input | 8 | 8-bit immediate |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |

## Verification
Every opcode's result is due exactly one clock edge after the cycle in which it is strobed, because the only register on the path is the output stage. The driver applies inputs at a falling edge. It queues each expected item tagged with the cycle count at which that item is due. The monitor pops an item only at the falling edge where the cycle count matches that tag, so each check looks at one settled edge. Idle cycles queue their own items, which expect a low strobe and an unchanged result, so the hold behaviour is checked at the same point.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ABS  = 3'd0,
    OP_POPC = 3'd1,
    OP_CTZ  = 3'd2,
    OP_SMAX = 3'd3,
    OP_SMIN = 3'd4,
    OP_UMAX = 3'd5,
    OP_UMIN = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_popcount.sv
module alu_popcount #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);
  localparam int NBYTES = W / 8;

  logic [3:0] byte_cnt [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_comb begin
      byte_cnt[g] = '0;
      for (int k = 0; k < 8; k++) begin
        byte_cnt[g] = byte_cnt[g] + {3'b000, val[g*8+k]};
      end
    end
  end

  always_comb begin
    cnt = '0;
    for (int j = 0; j < NBYTES; j++) begin
      cnt = cnt + CW'(byte_cnt[j]);
    end
  end
endmodule

// File: rtl/alu_ctz.sv
module alu_ctz #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] rev;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = val[W-1-g];
  end

  // leading-zero count of the reversed word
  always_comb begin
    logic found;
    found = 1'b0;
    cnt   = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && rev[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/alu_minmax.sv
module alu_minmax #(
  parameter int W = 64
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         is_signed,
  input  logic         is_max,
  output logic [W-1:0] res
);
  logic a_gt, a_lt, pick_a;

  always_comb begin
    if (is_signed) begin
      a_gt = $signed(opa) > $signed(opb);
      a_lt = $signed(opa) < $signed(opb);
    end else begin
      a_gt = opa > opb;
      a_lt = opa < opb;
    end
    pick_a = is_max ? a_gt : a_lt;
    res    = pick_a ? opa : opb;
  end

  // R6 and R7: the selected value bounds both operands in the chosen order
  always_comb begin
    if (is_signed && is_max)
      assert_minmax_order_R6: assert ($signed(res) >= $signed(opa) && $signed(res) >= $signed(opb));
    else if (is_signed)
      assert_minmax_lower_R6: assert ($signed(res) <= $signed(opa) && $signed(res) <= $signed(opb));
    else if (is_max)
      assert_umax_order_R7: assert (res >= opa && res >= opb);
    else
      assert_umin_order_R7: assert (res <= opa && res <= opb);
  end
endmodule

// File: rtl/bitcnt_minmax_alu.sv
module bitcnt_minmax_alu
  import alu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic            wide,
  input  logic            use_imm,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMM_W-1:0] imm8,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  alu_op_e op_e;
  logic    signed_op, minmax_op, is_max;
  logic [XLEN-1:0] a_sx, a_zx, b_sx, b_zx, imm_ext;
  logic [XLEN-1:0] mm_a, mm_b, mm_res, abs_res, pc_in, ctz_in, raw_res, final_res;
  logic [CW-1:0]   pc_cnt, ctz_cnt;
  logic            valid_d, valid_q;
  logic [XLEN-1:0] result_d, result_q;

  assign op_e      = alu_op_e'(op);
  assign signed_op = (op_e == OP_SMAX) || (op_e == OP_SMIN);
  assign minmax_op = (op_e == OP_SMAX) || (op_e == OP_SMIN) ||
                     (op_e == OP_UMAX) || (op_e == OP_UMIN);
  assign is_max    = (op_e == OP_SMAX) || (op_e == OP_UMAX);

  // width normalisation of operands
  always_comb begin
    a_sx = wide ? src_a : {{HALF{src_a[HALF-1]}}, src_a[HALF-1:0]};
    a_zx = wide ? src_a : {{HALF{1'b0}}, src_a[HALF-1:0]};
    b_sx = wide ? src_b : {{HALF{src_b[HALF-1]}}, src_b[HALF-1:0]};
    b_zx = wide ? src_b : {{HALF{1'b0}}, src_b[HALF-1:0]};
    imm_ext = signed_op ? {{(XLEN-IMM_W){imm8[IMM_W-1]}}, imm8}
                        : {{(XLEN-IMM_W){1'b0}}, imm8};
    mm_a = signed_op ? a_sx : a_zx;
    mm_b = use_imm ? imm_ext : (signed_op ? b_sx : b_zx);
  end

  // absolute value: negate only on a set sign bit, wraps at the minimum
  assign abs_res = a_sx[XLEN-1] ? (~a_sx + 1'b1) : a_sx;

  assign pc_in = a_zx;
  // a guard bit at HALF makes a zero low word count to HALF
  assign ctz_in = wide ? src_a : {{(HALF-1){1'b0}}, 1'b1, src_a[HALF-1:0]};

  alu_popcount #(.W(XLEN), .CW(CW)) i_popc (.val(pc_in), .cnt(pc_cnt));
  alu_ctz      #(.W(XLEN), .CW(CW)) i_ctz  (.val(ctz_in), .cnt(ctz_cnt));
  alu_minmax   #(.W(XLEN)) i_minmax (
    .opa(mm_a), .opb(mm_b), .is_signed(signed_op), .is_max(is_max), .res(mm_res)
  );

  always_comb begin
    unique case (op_e)
      OP_ABS:  raw_res = abs_res;
      OP_POPC: raw_res = {{(XLEN-CW){1'b0}}, pc_cnt};
      OP_CTZ:  raw_res = {{(XLEN-CW){1'b0}}, ctz_cnt};
      OP_SMAX, OP_SMIN, OP_UMAX, OP_UMIN: raw_res = minmax_op ? mm_res : '0;
      default: raw_res = '0;
    endcase
    final_res = wide ? raw_res : {{HALF{1'b0}}, raw_res[HALF-1:0]};
  end

  // next-state
  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    if (in_valid) result_d = final_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[XLEN-1:HALF] == '0));
  assert_ctz_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=> (result <= ($past(wide) ? XLEN : HALF)));
  assert_popc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1) |=> (result <= ($past(wide) ? XLEN : HALF)));
  assert_abs_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide && op == 3'd0 && src_a != {1'b1, {(XLEN-1){1'b0}}}) |=> !result[XLEN-1]);
  assert_unassigned_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (result == '0));
endmodule

// File: tb/test_bitcnt_minmax_alu.sv
`timescale 1ns/1ps
module test_bitcnt_minmax_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic        wide, use_imm;
  logic [63:0] src_a, src_b;
  logic [7:0]  imm8;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [63:0] last_exp = '0;

  typedef struct {
    int          due;
    logic        exp_valid;
    logic [63:0] exp_res;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitcnt_minmax_alu i_bitcnt_minmax_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm8(imm8),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [2:0] o, logic w, logic ui,
                                        logic [63:0] a, logic [63:0] b, logic [7:0] im);
    logic sg;
    logic [63:0] x, y, r;
    int n;
    sg = (o == 3 || o == 4);
    n  = w ? 64 : 32;
    x  = w ? a : ((sg || o == 0) ? {{32{a[31]}}, a[31:0]} : {32'b0, a[31:0]});
    if (ui) y = sg ? {{56{im[7]}}, im} : {56'b0, im};
    else    y = w ? b : (sg ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]});
    case (o)
      3'd0: r = x[63] ? (64'd0 - x) : x;
      3'd1: begin r = 0; for (int i = 0; i < n; i++) r = r + {63'b0, a[i]}; end
      3'd2: begin r = 64'(n); for (int i = n - 1; i >= 0; i--) if (a[i]) r = 64'(i); end
      3'd3: r = ($signed(x) > $signed(y)) ? x : y;
      3'd4: r = ($signed(x) < $signed(y)) ? x : y;
      3'd5: r = (x > y) ? x : y;
      3'd6: r = (x < y) ? x : y;
      default: r = '0;
    endcase
    return w ? r : {32'b0, r[31:0]};
  endfunction

  task automatic issue(input logic [2:0] o, input logic w, input logic ui,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] im, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op = o; wide = w; use_imm = ui; src_a = a; src_b = b; imm8 = im;
    it.due = cyc + 1; it.exp_valid = 1'b1; it.exp_res = model(o, w, ui, a, b, im);
    it.tag = tag;
    last_exp = it.exp_res;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b0; op = 3'd1; src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = '1; wide = 1'b1;
    it.due = cyc + 1; it.exp_valid = 1'b0; it.exp_res = last_exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " valid (R2)"}, {63'b0, out_valid}, {63'b0, it.exp_valid});
      check(it.tag, result, it.exp_res);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] lf;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; wide = 1'b1; use_imm = 1'b0;
    src_a = '0; src_b = '0; imm8 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'b0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", {63'b0, out_valid}, 64'd0);
    check("R1 after release result", result, 64'd0);

    issue(3'd0, 1, 0, 64'd25, 0, 0, "R3 abs positive");
    issue(3'd0, 1, 0, -64'sd77, 0, 0, "R3 abs negative");
    issue(3'd0, 1, 0, 64'h8000_0000_0000_0000, 0, 0, "R3 abs min wraps");
    issue(3'd0, 0, 0, 64'hABCD_0000_8000_0000, 0, 0, "R3 abs min32 wraps");
    issue(3'd0, 0, 0, 64'h1234_5678_FFFF_FFF0, 0, 0, "R3 R9 abs narrow");
    issue(3'd0, 1, 1, -64'sd9, 64'd3, 8'h80, "R8 abs ignores imm");
    issue(3'd1, 1, 0, '1, 0, 0, "R4 popcount all ones");
    issue(3'd1, 0, 0, '1, 0, 0, "R4 R9 popcount narrow");
    issue(3'd1, 1, 0, 64'hF0F0_0001_8000_0300, 0, 0, "R4 popcount pattern");
    idle("R2 idle hold");
    issue(3'd2, 1, 0, 0, 0, 0, "R5 ctz zero wide");
    issue(3'd2, 0, 0, 64'hFFFF_0000_0000_0000, 0, 0, "R5 R9 ctz zero narrow");
    issue(3'd2, 1, 0, 64'h8000_0000_0000_0000, 0, 0, "R5 ctz top bit");
    issue(3'd2, 1, 1, 64'h0000_0000_0001_0000, 0, 8'hFF, "R5 R8 ctz ignores imm");
    issue(3'd3, 1, 0, -64'sd5, 64'd3, 0, "R6 smax");
    issue(3'd4, 1, 0, -64'sd5, 64'd3, 0, "R6 smin");
    issue(3'd3, 1, 0, 64'd7, 64'd7, 0, "R6 smax equal");
    issue(3'd5, 1, 0, -64'sd5, 64'd3, 0, "R7 umax");
    issue(3'd6, 1, 0, -64'sd5, 64'd3, 0, "R7 umin");
    issue(3'd3, 1, 1, -64'sd100, 0, 8'hF0, "R8 smax imm sext");
    issue(3'd5, 1, 1, 64'd5, 0, 8'hF0, "R8 umax imm zext");
    issue(3'd4, 0, 1, 64'hFFFF_FFFF_0000_0010, 64'd0, 8'h80, "R8 R9 smin imm narrow");
    issue(3'd6, 0, 0, 64'h0000_0001_0000_0009, 64'hFFFF_0000_0000_0004, 0, "R9 umin narrow upper ignored");
    issue(3'd7, 1, 0, 64'd123, 64'd456, 8'h12, "R10 unassigned");
    idle("R2 idle after burst");
    idle("R2 second idle");

    lf = 64'h1D87_2B41_9C3E_5A66;
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a2;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      a2 = {lf[31:0], lf[63:32]} ^ 64'h5555_0000_AAAA_0000;
      issue(3'(k % 8), lf[5], lf[9], lf, a2, lf[23:16],
            (k % 8 < 3) ? "R4 R5 R3 sweep" : "R6 R7 R8 sweep");
      if (k % 37 == 0) idle("R2 sweep idle");
    end
    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2 pending results: actual %0d expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule